// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block sequences instruction addresses for a small 8-bit controller core whose instructions are 14 bits wide. It holds a 13-bit program counter that can reach 8K instruction words. It also holds an 8-deep hardware return stack, a 5-bit high-address latch, and the four-phase counter that sets the pace of execution. A decode stage sends one sequencing command per instruction cycle: plain advance, absolute jump, subroutine call, return, or return from interrupt. A single interrupt request line can redirect execution to a fixed vector.

Two of the block's registers sit on the core's data bus. One is the low byte of the program counter. The other is the high-address latch. A bus write to the low byte makes a computed jump: the latch supplies the upper five address bits in the same operation. Any change of flow is followed by one bubble instruction cycle, which stands for the flushed prefetch. During the bubble the counter holds and every input is ignored.

Top module: `prog_sequencer`

## Requirements
- R1: While `rstN` is low, `pc` is 0, the latch is 0, `phase` is 0 and `flush` is 0.
- R2: `phase` counts 0,1,2,3 and then back to 0. Inputs are acted on only at the clock edge that ends phase 3. `pc` changes at no other edge, so it changes at most once per instruction cycle.
- R3: Code 0 means advance. Codes 5, 6 and 7 also mean advance. An advance with no bus write to the low byte and no interrupt taken sets `pc` to `pc`+1, wrapping from 0x1FFF to 0x0000. It does not set `flush`.
- R4: A bus write with `regSel`=1 loads `wrData[4:0]` into the latch. A read with `regSel`=1 returns the latch in bits 4:0 and zeros in bits 7:5. A latch write alone does not change `pc`.
- R5: A bus write with `regSel`=0 sets `pc` to {latch[4:0], `wrData`}. A read with `regSel`=0 returns `pc[7:0]`. `rdData` follows `regSel` combinationally.
- R6: Code 1 (jump) sets `pc` to {latch[4:3], `jumpTgt[10:0]`}.
- R7: Code 2 (call) pushes `pc`+1 and jumps exactly as code 1 does. Code 3 (return) pops the most recent entry into `pc`.
- R8: The stack has 8 entries of 13 bits with a wrapping pointer. A ninth push overwrites the oldest entry, and a pop past the bottom wraps. No flag is raised in either case.
- R9: An interrupt is taken when `irqReq` is high on an advance with no low-byte write and the block is not already servicing one. Taking it pushes `pc`+1, sets `pc` to 0x004 and enters service. While in service, `irqReq` is ignored. Code 4 pops like a return and leaves service.
- R10: A low-byte write, jump, call, return, return from interrupt or taken interrupt raises `flush` for the whole next instruction cycle. During that bubble, `pc` holds, and commands, bus writes and `irqReq` have no effect.
- R11: Priority is: low-byte bus write, then a non-advance command, then the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; four cycles make one instruction cycle |
| rstN | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Sequencing command from decode (0 advance, 1 jump, 2 call, 3 return, 4 return from interrupt) |
| jumpTgt | input | 11 | Target field for jump and call |
| irqReq | input | 1 | Interrupt request |
| regWrEn | input | 1 | Data-bus write strobe for this block's registers |
| regSel | input | 1 | Register select: 0 low PC byte, 1 high-address latch |
| wrData | input | 8 | Data-bus write value |
| rdData | output | 8 | Data-bus read value of the selected register |
| pc | output | 13 | Current program counter |
| phase | output | 2 | Quadrature phase within the instruction cycle |
| flush | output | 1 | High during the bubble cycle after a change of flow |

## Verification
Straight runs of advances show the plain step and the wrap at the top of memory. Jumps and low-byte writes made after different latch values show which latch bits feed each kind of target. Nested calls and returns show the stack order. A run of nine calls followed by nine returns shows that the pointer wraps and the oldest entry is overwritten. Interrupts are raised under several conditions: during a bubble, during service, together with a jump, and together with a low-byte write. These cases separate the priority rules from the nesting block. Junk commands are driven during phases 0 to 2, so any gating that is not tied to the phase shows up as a wrong `pc`.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_NEXT = 3'd0,
    SEQ_GOTO = 3'd1,
    SEQ_CALL = 3'd2,
    SEQ_RET  = 3'd3,
    SEQ_RETI = 3'd4
  } seq_cmd_e;

  // one-cycle strobes from control to datapath, valid at the phase-end edge
  typedef struct packed {
    logic step;     // pc + 1
    logic loadLow;  // computed jump from bus write
    logic jump;     // jump or call target
    logic push;     // push pc + 1
    logic pop;      // load pc from stack top
    logic vector;   // load interrupt vector
    logic latchWr;  // write high-address latch
  } seq_strobe_t;

endpackage

// File: rtl/prog_seq_ctrl.sv
module prog_seq_ctrl
  import prog_seq_pkg::*;
#(
  parameter int PHASES = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [2:0]                  cmd,
  input  logic                        regWrEn,
  input  logic                        regSel,
  input  logic                        irqReq,
  output logic [$clog2(PHASES)-1:0]   phase,
  output logic                        flush,
  output logic                        inService,
  output seq_strobe_t                 strobe
);

  localparam int PH_W = $clog2(PHASES);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

  logic [PH_W-1:0] phaseQ;
  logic            flushQ;
  logic            inSvcQ;
  logic            boundary;
  logic            active;
  logic            irqHit;
  logic            retiHit;
  logic            changeFlow;

  assign boundary = (phaseQ == LAST_PH);
  assign active   = boundary && !flushQ;

  always_ff @(posedge clk) begin
    if (!rstN) phaseQ <= '0;
    else if (boundary) phaseQ <= '0;
    else phaseQ <= phaseQ + PH_W'(1);
  end

  always_comb begin
    strobe  = '0;
    irqHit  = 1'b0;
    retiHit = 1'b0;
    strobe.latchWr = active && regWrEn && regSel;
    if (active && regWrEn && !regSel) begin
      strobe.loadLow = 1'b1;
    end else if (active) begin
      case (seq_cmd_e'(cmd))
        SEQ_GOTO: strobe.jump = 1'b1;
        SEQ_CALL: begin
          strobe.jump = 1'b1;
          strobe.push = 1'b1;
        end
        SEQ_RET:  strobe.pop = 1'b1;
        SEQ_RETI: begin
          strobe.pop = 1'b1;
          retiHit    = 1'b1;
        end
        default: begin
          if (irqReq && !inSvcQ) begin
            strobe.push   = 1'b1;
            strobe.vector = 1'b1;
            irqHit        = 1'b1;
          end else begin
            strobe.step = 1'b1;
          end
        end
      endcase
    end
  end

  assign changeFlow = strobe.loadLow | strobe.jump | strobe.pop | strobe.vector;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flushQ <= 1'b0;
      inSvcQ <= 1'b0;
    end else begin
      if (boundary) flushQ <= changeFlow;
      if (irqHit) inSvcQ <= 1'b1;
      else if (retiHit) inSvcQ <= 1'b0;
    end
  end

  assign phase     = phaseQ;
  assign flush     = flushQ;
  assign inService = inSvcQ;

endmodule

// File: rtl/prog_seq_path.sv
module prog_seq_path
  import prog_seq_pkg::*;
#(
  parameter int          PC_W   = 13,
  parameter int          DATA_W = 8,
  parameter int          TGT_W  = 11,
  parameter int          DEPTH  = 8,
  parameter logic [31:0] VECTOR = 32'h4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  logic [TGT_W-1:0]  jumpTgt,
  input  logic [DATA_W-1:0] wrData,
  input  logic              regSel,
  output logic [DATA_W-1:0] rdData,
  output logic [PC_W-1:0]   pc
);

  localparam int HI_W  = PC_W - DATA_W;
  localparam int SEL_W = PC_W - TGT_W;
  localparam int SP_W  = $clog2(DEPTH);

  logic [PC_W-1:0] pcQ;
  logic [HI_W-1:0] latchQ;
  logic [SP_W-1:0] spQ;
  logic [PC_W-1:0] stackQ [DEPTH];
  logic [PC_W-1:0] retAddr;
  logic [PC_W-1:0] jumpAddr;
  logic [PC_W-1:0] popAddr;
  logic [SP_W-1:0] topIdx;

  assign retAddr = pcQ + PC_W'(1);
  assign topIdx  = spQ - SP_W'(1);
  assign popAddr = stackQ[topIdx];

  generate
    if (SEL_W > 0) begin : g_paged
      assign jumpAddr = {latchQ[HI_W-1 -: SEL_W], jumpTgt};
    end else begin : g_flat
      assign jumpAddr = jumpTgt[PC_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ <= '0;
    end else if (strobe.loadLow) begin
      pcQ <= {latchQ, wrData};
    end else if (strobe.jump) begin
      pcQ <= jumpAddr;
    end else if (strobe.pop) begin
      pcQ <= popAddr;
    end else if (strobe.vector) begin
      pcQ <= PC_W'(VECTOR);
    end else if (strobe.step) begin
      pcQ <= retAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) latchQ <= '0;
    else if (strobe.latchWr) latchQ <= wrData[HI_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spQ <= '0;
      for (int i = 0; i < DEPTH; i++) stackQ[i] <= '0;
    end else if (strobe.push) begin
      for (int i = 0; i < DEPTH; i++)
        if (spQ == SP_W'(i)) stackQ[i] <= retAddr;
      spQ <= spQ + SP_W'(1);
    end else if (strobe.pop) begin
      spQ <= topIdx;
    end
  end

  assign rdData = regSel ? DATA_W'(latchQ) : pcQ[DATA_W-1:0];
  assign pc     = pcQ;

endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
  import prog_seq_pkg::*;
#(
  parameter int          PC_W   = 13,
  parameter int          DATA_W = 8,
  parameter int          TGT_W  = 11,
  parameter int          DEPTH  = 8,
  parameter int          PHASES = 4,
  parameter logic [31:0] VECTOR = 32'h4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [2:0]                cmd,
  input  logic [TGT_W-1:0]          jumpTgt,
  input  logic                      irqReq,
  input  logic                      regWrEn,
  input  logic                      regSel,
  input  logic [DATA_W-1:0]         wrData,
  output logic [DATA_W-1:0]         rdData,
  output logic [PC_W-1:0]           pc,
  output logic [$clog2(PHASES)-1:0] phase,
  output logic                      flush
);

  seq_strobe_t seqStrobe;
  logic        ctrlInSvc;

  prog_seq_ctrl #(.PHASES(PHASES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .irqReq    (irqReq),
    .phase     (phase),
    .flush     (flush),
    .inService (ctrlInSvc),
    .strobe    (seqStrobe)
  );

  prog_seq_path #(
    .PC_W(PC_W), .DATA_W(DATA_W), .TGT_W(TGT_W), .DEPTH(DEPTH), .VECTOR(VECTOR)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (seqStrobe),
    .jumpTgt (jumpTgt),
    .wrData  (wrData),
    .regSel  (regSel),
    .rdData  (rdData),
    .pc      (pc)
  );

endmodule

// File: rtl/prog_sequencer_chk.sv
module prog_sequencer_chk #(
  parameter int          PC_W   = 13,
  parameter int          PH_W   = 2,
  parameter logic [31:0] VECTOR = 32'h4
) (
  input logic            clk,
  input logic            rstN,
  input logic [PH_W-1:0] phase,
  input logic [PC_W-1:0] pc,
  input logic            flush,
  input logic [2:0]      cmd,
  input logic            regWrEn,
  input logic            irqReq,
  input logic            inService
);

  localparam logic [PH_W-1:0] LAST_PH = '1;

  logic lastPh;
  logic plainNext;
  assign lastPh    = (phase == LAST_PH);
  assign plainNext = lastPh && !flush && !regWrEn && (cmd == 3'd0);

  a_r2_phase_count: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> phase == $past(phase) + PH_W'(1));

  a_r2_pc_only_at_end: assert property (@(posedge clk) disable iff (!rstN)
    !lastPh |=> $stable(pc));

  a_r10_bubble_holds: assert property (@(posedge clk) disable iff (!rstN)
    (lastPh && flush) |=> $stable(pc) && !flush);

  a_r3_plain_step: assert property (@(posedge clk) disable iff (!rstN)
    (plainNext && !irqReq) |=> (pc == $past(pc) + PC_W'(1)) && !flush);

  a_r9_take_vector: assert property (@(posedge clk) disable iff (!rstN)
    (plainNext && irqReq && !inService) |=> (pc == PC_W'(VECTOR)) && flush && inService);

  a_r9_no_nesting: assert property (@(posedge clk) disable iff (!rstN)
    (plainNext && inService) |=> inService && (pc == $past(pc) + PC_W'(1)));

  a_r10_jump_bubble: assert property (@(posedge clk) disable iff (!rstN)
    (lastPh && !flush && !regWrEn && cmd == 3'd1) |=> flush);

endmodule

bind prog_sequencer prog_sequencer_chk #(
  .PC_W(PC_W), .PH_W($clog2(PHASES)), .VECTOR(VECTOR)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .phase     (phase),
  .pc        (pc),
  .flush     (flush),
  .cmd       (cmd),
  .regWrEn   (regWrEn),
  .irqReq    (irqReq),
  .inService (ctrlInSvc)
);

// File: tb/prog_sequencer_tb.sv
`timescale 1ns/1ps
module prog_sequencer_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [2:0]  cmd;
  logic [10:0] jumpTgt;
  logic        irqReq;
  logic        regWrEn;
  logic        regSel;
  logic [7:0]  wrData;
  logic [7:0]  rdData;
  logic [12:0] pc;
  logic [1:0]  phase;
  logic        flush;

  always #2.5 clk = ~clk;

  prog_sequencer u_dut (
    .clk(clk), .rstN(rstN), .cmd(cmd), .jumpTgt(jumpTgt), .irqReq(irqReq),
    .regWrEn(regWrEn), .regSel(regSel), .wrData(wrData), .rdData(rdData),
    .pc(pc), .phase(phase), .flush(flush)
  );

  typedef struct {
    logic [12:0] pc;
    logic        fl;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int   nChk = 0;
  int   nFail = 0;
  bit   done = 0;

  // reference model state
  logic [12:0] mPc;
  logic [4:0]  mLatch;
  logic [12:0] mStk [8];
  logic [2:0]  mSp;
  logic        mSvc;
  logic        mFlush;

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  endtask

  // monitor: compare design outputs with scoreboard items
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t it;
      it = expQ.pop_front();
      check({it.tag, " pc"}, pc, it.pc);
      check({it.tag, " flush"}, {12'd0, flush}, {12'd0, it.fl});
    end
  end

  task automatic junk();
    cmd = 3'd1; jumpTgt = 11'h5A5; irqReq = 1'b1;
    regWrEn = 1'b1; regSel = 1'b0; wrData = 8'hC3;
  endtask

  task automatic modelStep(input logic [2:0] c, input logic [10:0] t, input logic we,
                           input logic sel, input logic [7:0] d, input logic irq);
    logic chg;
    logic [4:0] newLatch;
    chg = 1'b0;
    newLatch = mLatch;
    if (mFlush) begin
      mFlush = 1'b0;
    end else begin
      if (we && !sel) begin
        mPc = {mLatch, d};
        chg = 1'b1;
      end else begin
        if (we && sel) newLatch = d[4:0];
        case (c)
          3'd1: begin mPc = {mLatch[4:3], t}; chg = 1'b1; end
          3'd2: begin
            mStk[mSp] = mPc + 13'd1; mSp = mSp + 3'd1;
            mPc = {mLatch[4:3], t}; chg = 1'b1;
          end
          3'd3, 3'd4: begin
            mSp = mSp - 3'd1; mPc = mStk[mSp]; chg = 1'b1;
            if (c == 3'd4) mSvc = 1'b0;
          end
          default: begin
            if (irq && !mSvc) begin
              mStk[mSp] = mPc + 13'd1; mSp = mSp + 3'd1;
              mPc = 13'h004; mSvc = 1'b1; chg = 1'b1;
            end else begin
              mPc = mPc + 13'd1;
            end
          end
        endcase
      end
      mLatch = newLatch;
      mFlush = chg;
    end
  endtask

  // driver: one instruction cycle; junk is driven in the other phases (R2)
  task automatic instr(input logic [2:0] c, input logic [10:0] t, input logic we,
                       input logic sel, input logic [7:0] d, input logic irq, input string tag);
    while (phase != 2'd3) begin
      @(posedge clk);
      expQ.push_back('{pc: mPc, fl: mFlush, tag: "R2 hold"});
      @(negedge clk);
    end
    cmd = c; jumpTgt = t; regWrEn = we; regSel = sel; wrData = d; irqReq = irq;
    @(posedge clk);
    modelStep(c, t, we, sel, d, irq);
    expQ.push_back('{pc: mPc, fl: mFlush, tag: tag});
    @(negedge clk);
    junk();
  endtask

  task automatic nxt(input string tag);
    instr(3'd0, 11'd0, 1'b0, 1'b0, 8'd0, 1'b0, tag);
  endtask

  task automatic readReg(input logic sel, input logic [7:0] exp, input string tag);
    regWrEn = 1'b0; regSel = sel;
    #1;
    check(tag, {5'd0, rdData}, {5'd0, exp});
    junk();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    logic [12:0] firstRet;
    rstN = 1'b0;
    junk();
    mPc = '0; mLatch = '0; mSp = '0; mSvc = 1'b0; mFlush = 1'b0;
    for (int i = 0; i < 8; i++) mStk[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 pc", pc, 13'h0);
    check("R1 flush", {12'd0, flush}, 13'd0);
    check("R1 phase", {11'd0, phase}, 13'd0);
    regSel = 1'b1; regWrEn = 1'b0; #1;
    check("R1 latch", {5'd0, rdData}, 13'd0);
    junk();
    rstN = 1'b1;

    // R3 plain advance, R5 low-byte read
    nxt("R3 step"); nxt("R3 step"); nxt("R3 step");
    readReg(1'b0, 8'h03, "R5 read low");
    instr(3'd7, 11'd0, 1'b0, 1'b0, 8'd0, 1'b0, "R3 code7 advance");
    // R4 latch write with advance, top bits read zero
    instr(3'd0, 11'd0, 1'b1, 1'b1, 8'hFF, 1'b0, "R4 latch write");
    check("R4 pc unaffected", pc, 13'h005);
    readReg(1'b1, 8'h1F, "R4 read latch");
    // R6 jump uses latch[4:3]
    instr(3'd1, 11'h123, 1'b0, 1'b0, 8'd0, 1'b0, "R6 jump");
    check("R6 jump target", pc, 13'h1923);
    instr(3'd2, 11'h000, 1'b1, 1'b0, 8'h00, 1'b1, "R10 bubble ignores");
    nxt("R3 after jump");
    // R5 computed jump, R11 beats jump command
    instr(3'd1, 11'h7FF, 1'b1, 1'b0, 8'h40, 1'b0, "R11 low write over jump");
    check("R5 computed jump", pc, 13'h1F40);
    nxt("R10 bubble"); nxt("R3 step");
    readReg(1'b0, 8'h41, "R5 read low");
    // R3 wrap at top
    instr(3'd0, 11'd0, 1'b1, 1'b0, 8'hFF, 1'b0, "R5 to top");
    nxt("R10 bubble"); nxt("R3 wrap");
    check("R3 wrap to zero", pc, 13'h0000);
    instr(3'd0, 11'd0, 1'b1, 1'b1, 8'h00, 1'b0, "R4 latch clear");
    // R7 nested call/return
    instr(3'd2, 11'h100, 1'b0, 1'b0, 8'd0, 1'b0, "R7 call"); nxt("R10 bubble");
    instr(3'd2, 11'h200, 1'b0, 1'b0, 8'd0, 1'b0, "R7 call"); nxt("R10 bubble");
    instr(3'd3, 11'd0, 1'b0, 1'b0, 8'd0, 1'b0, "R7 return");
    check("R7 return inner", pc, 13'h101);
    nxt("R10 bubble");
    instr(3'd3, 11'd0, 1'b0, 1'b0, 8'd0, 1'b0, "R7 return");
    check("R7 return outer", pc, 13'h002);
    nxt("R10 bubble");
    // R8 nine pushes, nine pops
    for (int i = 0; i < 9; i++) begin
      instr(3'd2, 11'(11'h300 + i * 16), 1'b0, 1'b0, 8'd0, 1'b0, "R8 push");
      nxt("R10 bubble");
    end
    for (int i = 0; i < 9; i++) begin
      instr(3'd3, 11'd0, 1'b0, 1'b0, 8'd0, 1'b0, "R8 pop");
      if (i == 0) firstRet = pc;
      if (i == 8) check("R8 wrapped pop", pc, firstRet);
      nxt("R10 bubble");
    end
    // R9 interrupt entry, no nesting, return
    nxt("R3 step");
    instr(3'd0, 11'd0, 1'b0, 1'b0, 8'd0, 1'b1, "R9 take irq");
    check("R9 vector", pc, 13'h004);
    instr(3'd0, 11'd0, 1'b0, 1'b0, 8'd0, 1'b1, "R10 bubble irq");
    instr(3'd0, 11'd0, 1'b0, 1'b0, 8'd0, 1'b1, "R9 no nesting");
    check("R9 no nesting", pc, 13'h005);
    instr(3'd4, 11'd0, 1'b0, 1'b0, 8'd0, 1'b1, "R9 return from irq");
    nxt("R10 bubble");
    instr(3'd1, 11'h050, 1'b0, 1'b0, 8'd0, 1'b1, "R11 jump over irq");
    check("R11 jump over irq", pc, 13'h050);
    nxt("R10 bubble");
    instr(3'd0, 11'd0, 1'b1, 1'b0, 8'h77, 1'b1, "R11 low write over irq");
    nxt("R10 bubble");
    instr(3'd0, 11'd0, 1'b0, 1'b0, 8'd0, 1'b1, "R9 irq again");
    check("R9 vector again", pc, 13'h004);
    nxt("R10 bubble");
    instr(3'd4, 11'd0, 1'b0, 1'b0, 8'd0, 1'b0, "R9 return from irq");
    check("R9 resume", pc, 13'h078);
    nxt("R10 bubble");
    nxt("R3 step");

    @(negedge clk);
    @(negedge clk);
    finishRun();
  end

endmodule